// File: doc/BRIEF.md
# Keyed System Reset Request Register

This block is a single 32-bit control register on a simple register bus. Its purpose is to let software request a system-level reset. A write has effect only when the upper half-word of the write data carries a fixed 16-bit unlock key. A write that lacks the key is dropped entirely, and a one-cycle key-miss strobe is raised for visibility.

An accepted write with the reset-request bit set produces a single-cycle request pulse for an external reset sequencer. The reserved guard bit must be written as 0. An accepted write that sets the guard bit raises a sticky error flag and does nothing else.

Every control bit is write-only. A read returns zeros apart from a fixed endianness flag, and that flag reports little-endian in the default build.

Top module: `keyed_rst_ctl`

## Requirements
- R1: A write is accepted only when wr_data[31:16] equals 16'h05FA. With any other key, the write leaves rst_req low and leaves bad_wr unchanged.
- R2: An accepted write with wr_data[2]=1 and wr_data[1]=0 drives rst_req high for the one clock cycle that follows the write edge. An accepted write with wr_data[2]=0 produces no request.
- R3: A rejected write drives key_miss high for the one cycle following its write edge. key_miss is low in every other cycle.
- R4: An accepted write with wr_data[1]=1 sets bad_wr. bad_wr stays set until reset, and that write does not raise rst_req.
- R5: rd_data, one cycle after a read strobe, is all zeros in the default little-endian build. Bit 15 is the endianness flag (0 = little), and bits 2 and 1 always read 0. When no read was strobed, rd_data is 0.
- R6: While reset is asserted, and straight after it, rst_req, key_miss, bad_wr and rd_data are all 0.
- R7: Bit 0 and bits [14:3] of an accepted write have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data, with the key in the upper half |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| rst_req | output | 1 | One-cycle system reset request |
| key_miss | output | 1 | One-cycle strobe for a write with a wrong key |
| bad_wr | output | 1 | Sticky flag for a guard-bit violation |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it:
- rst_req and key_miss appear in the cycle after the write edge.
- bad_wr sets in the cycle after the write edge and then holds.
- rd_data follows rd_en by one edge.

The bench applies each stimulus at a falling edge. It then waits for the next falling edge, so exactly one rising edge has passed, and compares all outputs against a model updated from that same stimulus. A sticky copy of bad_wr in the model carries state across cycles, and random idle cycles between writes confirm that the pulses drop again.

// File: rtl/keyed_rst_pkg.sv
package keyed_rst_pkg;
   typedef struct packed {
      logic accept;   // write with correct key
      logic reject;   // write with wrong key
      logic req;      // accepted, request bit set, guard clear
      logic guard;    // accepted, guard bit set
   } wr_decode_t;
endpackage

// File: rtl/krr_key_check.sv
module krr_key_check
   import keyed_rst_pkg::*;
#(
   parameter int unsigned          DATA_W    = 32,
   parameter int unsigned          KEY_W     = 16,
   parameter logic [KEY_W-1:0]     KEY_VAL   = 16'h05FA,
   parameter int unsigned          REQ_BIT   = 2,
   parameter int unsigned          GUARD_BIT = 1
) (
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output wr_decode_t        dec
);
   localparam int unsigned KEY_LSB = DATA_W - KEY_W;

   logic key_ok;
   assign key_ok = (wr_data[DATA_W-1:KEY_LSB] == KEY_VAL);

   always_comb begin
      dec.accept = wr_en & key_ok;
      dec.reject = wr_en & ~key_ok;
      dec.guard  = dec.accept & wr_data[GUARD_BIT];
      dec.req    = dec.accept & wr_data[REQ_BIT] & ~wr_data[GUARD_BIT];
   end
endmodule

// File: rtl/krr_event_regs.sv
module krr_event_regs
   import keyed_rst_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  wr_decode_t dec,
   output logic       rst_req,
   output logic       key_miss,
   output logic       bad_wr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req  <= 1'b0;
         key_miss <= 1'b0;
         bad_wr   <= 1'b0;
      end else begin
         rst_req  <= dec.req;
         key_miss <= dec.reject;
         if (dec.guard) bad_wr <= 1'b1;
      end
   end
endmodule

// File: rtl/krr_readback.sv
module krr_readback #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ENDIAN_BIT = 15,
   parameter bit          BIG_ENDIAN = 1'b0,
   parameter bit          RD_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data
);
   localparam logic [DATA_W-1:0] RD_VAL = DATA_W'(BIG_ENDIAN) << ENDIAN_BIT;

   generate
      if (RD_REG) begin : g_reg
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= rd_en ? RD_VAL : '0;
         end
         assign rd_data = q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign rd_data = rd_en ? RD_VAL : '0;
      end
   endgenerate
endmodule

// File: rtl/keyed_rst_ctl.sv
module keyed_rst_ctl
   import keyed_rst_pkg::*;
#(
   parameter int unsigned      DATA_W     = 32,
   parameter int unsigned      KEY_W      = 16,
   parameter logic [KEY_W-1:0] KEY_VAL    = 16'h05FA,
   parameter int unsigned      REQ_BIT    = 2,
   parameter int unsigned      GUARD_BIT  = 1,
   parameter int unsigned      ENDIAN_BIT = 15,
   parameter bit               BIG_ENDIAN = 1'b0,
   parameter bit               RD_REG     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              rst_req,
   output logic              key_miss,
   output logic              bad_wr
);
   generate
      if (KEY_W >= DATA_W) begin : g_chk_key
         $error("key field must leave room for control bits");
      end
      if (REQ_BIT >= DATA_W - KEY_W || GUARD_BIT >= DATA_W - KEY_W ||
          ENDIAN_BIT >= DATA_W - KEY_W) begin : g_chk_pos
         $error("control bit positions overlap the key field");
      end
      if (REQ_BIT == GUARD_BIT) begin : g_chk_dup
         $error("request and guard bits must differ");
      end
   endgenerate

   wr_decode_t dec;

   krr_key_check #(
      .DATA_W(DATA_W), .KEY_W(KEY_W), .KEY_VAL(KEY_VAL),
      .REQ_BIT(REQ_BIT), .GUARD_BIT(GUARD_BIT)
   ) key_i (
      .wr_en(wr_en), .wr_data(wr_data), .dec(dec)
   );

   krr_event_regs evt_i (
      .clk(clk), .rst_n(rst_n), .dec(dec),
      .rst_req(rst_req), .key_miss(key_miss), .bad_wr(bad_wr)
   );

   krr_readback #(
      .DATA_W(DATA_W), .ENDIAN_BIT(ENDIAN_BIT),
      .BIG_ENDIAN(BIG_ENDIAN), .RD_REG(RD_REG)
   ) rd_i (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_data(rd_data)
   );
endmodule

// File: rtl/keyed_rst_ctl_chk.sv
module keyed_rst_ctl_chk #(
   parameter int unsigned      DATA_W     = 32,
   parameter int unsigned      KEY_W      = 16,
   parameter logic [KEY_W-1:0] KEY_VAL    = 16'h05FA,
   parameter int unsigned      REQ_BIT    = 2,
   parameter int unsigned      GUARD_BIT  = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              rst_req,
   input logic              key_miss,
   input logic              bad_wr
);
   logic key_hit;
   assign key_hit = (wr_data[DATA_W-1 -: KEY_W] == KEY_VAL);

   // R1, R2: a request only follows a keyed write with guard clear
   p_req_needs_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> $past(wr_en && key_hit && wr_data[REQ_BIT] && !wr_data[GUARD_BIT]));

   // R2: a keyed request write is followed by the pulse
   p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && key_hit && wr_data[REQ_BIT] && !wr_data[GUARD_BIT]) |=> rst_req);

   // R3: a wrong key gives a miss strobe and no request
   p_miss_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !key_hit) |=> (key_miss && !rst_req));

   // R3: no miss without a rejected write
   p_miss_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      key_miss |-> $past(wr_en && !key_hit));

   // R4: the error flag is sticky
   p_err_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bad_wr |=> bad_wr);

   // R4: the error flag sets only on a keyed guard write
   p_err_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bad_wr) |-> $past(wr_en && key_hit && wr_data[GUARD_BIT]));

   // R5: the write-only bits never read back
   p_wo_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[REQ_BIT] == 1'b0) && (rd_data[GUARD_BIT] == 1'b0));
endmodule

bind keyed_rst_ctl keyed_rst_ctl_chk #(
   .DATA_W(DATA_W), .KEY_W(KEY_W), .KEY_VAL(KEY_VAL),
   .REQ_BIT(REQ_BIT), .GUARD_BIT(GUARD_BIT)
) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
   .rd_data(rd_data), .rst_req(rst_req), .key_miss(key_miss), .bad_wr(bad_wr)
);

// File: tb/keyed_rst_ctl_tb_top.sv
module keyed_rst_ctl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] KEY = 16'h05FA;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [31:0] rd_data;
   logic        rst_req, key_miss, bad_wr;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   bit m_err = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   keyed_rst_ctl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .rst_req(rst_req),
      .key_miss(key_miss), .bad_wr(bad_wr)
   );

   function automatic bit f_accept(bit we, logic [31:0] d);
      return we && (d[31:16] == KEY);
   endfunction

   function automatic bit f_req(bit we, logic [31:0] d);
      return f_accept(we, d) && d[2] && !d[1];
   endfunction

   function automatic bit f_miss(bit we, logic [31:0] d);
      return we && (d[31:16] != KEY);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   // drive at a falling edge, check at the next falling edge
   task automatic step(bit we, logic [31:0] d, bit re, string tag);
      wr_en   = we;
      wr_data = d;
      rd_en   = re;
      @(negedge clk);
      if (f_accept(we, d) && d[1]) m_err = 1'b1;
      check({tag, " R2 rst_req"}, 32'(rst_req), 32'(f_req(we, d)));
      check({tag, " R3 key_miss"}, 32'(key_miss), 32'(f_miss(we, d)));
      check({tag, " R4 bad_wr"}, 32'(bad_wr), 32'(m_err));
      check({tag, " R5 rd_data"}, rd_data, 32'h0);
      wr_en = 1'b0;
      rd_en = 1'b0;
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'd1234));
      repeat (2) @(negedge clk);
      // R6: reset state
      check("R6 rst_req", 32'(rst_req), 0);
      check("R6 key_miss", 32'(key_miss), 0);
      check("R6 bad_wr", 32'(bad_wr), 0);
      check("R6 rd_data", rd_data, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed corners
      step(1, {KEY, 16'h0004}, 0, "R2 keyed request");
      step(0, 32'h0, 0, "R2 pulse ends");
      step(1, {16'h05FB, 16'h0004}, 0, "R1 near key");
      step(1, {16'h0000, 16'hFFFF}, 0, "R1 zero key");
      step(1, {KEY, 16'h0000}, 1, "R2 keyed no request");
      step(1, {KEY, 16'hFFF9}, 1, "R7 other bits set");
      step(1, {16'hFA05, 16'h0006}, 0, "R1 swapped key guard");
      step(1, {KEY, 16'h0004}, 0, "R2 back to back a");
      step(1, {KEY, 16'h0004}, 0, "R2 back to back b");
      step(1, {KEY, 16'h0006}, 0, "R4 guard with request");
      step(0, 32'h0, 1, "R4 sticky");
      step(1, {KEY, 16'h0004}, 0, "R2 request after error");

      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [31:0] d;
         bit we;
         d  = $urandom;
         we = ($urandom % 4) != 0;
         if (($urandom % 2) == 0) d[31:16] = KEY;
         if (($urandom % 4) != 0) d[1] = 1'b0;
         step(we, d, 1'($urandom), "R1 random");
      end

      // reset again clears the sticky flag
      rst_n = 1'b0;
      m_err = 1'b0;
      @(negedge clk);
      check("R6 bad_wr after reset", 32'(bad_wr), 0);
      rst_n = 1'b1;
      @(negedge clk);
      step(1, {KEY, 16'h0004}, 1, "R2 after reset");

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule